// File: doc/BRIEF.md
# Congestion-Driven Sender Rate Controller

This block sets the send rate of one flow from the congestion feedback that reaches it. The rate is held as a 16-bit unsigned fraction of line rate, where 0xFFFF means full line rate. When a congestion notification strobe arrives, the rate is cut at once by a configurable factor. The rate held just before the cut becomes the target for recovery. After that the block climbs back in stages. Each step is set off by one of two independent triggers: enough transmitted bytes, or enough elapsed time ticks. The time trigger lets a flow that sends little still regain its rate.

Recovery has three stages. In the first stage the rate closes half the gap to the target on each step. In the second stage the target is also raised by a small additive step. In the third stage, reached only once both triggers have fired often enough, the target is raised by a larger step. A token bucket turns the current rate into a pacing enable for the transmit path.

None of the inputs is a stream. The notification strobe, the byte count and the tick are sampled every cycle and are never back-pressured. The pacing enable is the only flow control that the block gives back. Configuration inputs are expected to stay stable while the block is running.

Top module: `cong_rate_ctl`

## Requirements
- R1: During and right after reset, `rate_o` is 0xFFFF and `pace_o` is 0, and both internal recovery targets start at 0xFFFF.
- R2: A cycle with `cnp_i` high sets the rate, from the next cycle, to max(floor(rate × `cut_factor_i` / 256), `min_rate_i`). The factor is unsigned Q0.8, so 205 gives about 0.8.
- R3: A notification loads the target with the rate held just before the cut. The first 5 recovery events after a notification each set rate := floor((rate + target) / 2) and leave the target unchanged.
- R4: Each later recovery event first sets target := min(target + `ai_step_i`, 0xFFFF) and then sets rate := floor((rate + target) / 2).
- R5: When the byte trigger and the timer trigger have each fired at least 5 times since the last notification (counting the firing in the current cycle), the step added to the target is `hai_step_i` instead of `ai_step_i`.
- R6: The byte trigger adds `tx_bytes_i` to an accumulator. It fires in a cycle where `tx_bytes_i` is nonzero and the accumulator plus `tx_bytes_i` is at least `byte_thresh_i`. When it fires, the accumulator returns to 0.
- R7: The timer trigger counts cycles in which `tick_i` is high. It fires on the tick that brings the count to `timer_period_i` and then restarts from 0, whatever the byte traffic. A cycle in which either trigger fires counts as one recovery event.
- R8: A notification clears both accumulators, both firing counts and the event count. It also takes precedence over any trigger that fires in the same cycle.
- R9: A token balance, kept in units of 1/65536 byte, gains rate × LINE_BYTES per cycle and loses `tx_bytes_i` × 65536. It is clamped to ±BURST_BYTES × 65536 and starts at 0. `pace_o` is high exactly while the registered balance is above 0.
- R10: `rate_o` never goes below `min_rate_i`, never exceeds 0xFFFF and never exceeds the recovery target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnp_i | input | 1 | Congestion notification strobe, one cycle per notification |
| tx_bytes_i | input | 8 | Bytes transmitted by the flow this cycle |
| tick_i | input | 1 | Time-base tick for the recovery timer |
| cut_factor_i | input | 8 | Multiplicative cut factor, Q0.8 |
| min_rate_i | input | 16 | Rate floor; a cut never goes below it |
| ai_step_i | input | 16 | Additive-increase step for the target |
| hai_step_i | input | 16 | Hyper-increase step for the target |
| byte_thresh_i | input | 16 | Bytes per byte-trigger firing |
| timer_period_i | input | 16 | Ticks per timer-trigger firing |
| rate_o | output | 16 | Current rate, fraction of line rate |
| pace_o | output | 1 | Token-bucket pacing enable |

## Verification
The hardest state to reach is the hyper-increase stage. It needs five events in the halving stage and then at least five firings of each trigger, all with no notification in between. A flow that sends bytes but never ticks, or ticks but sends nothing, stays in the additive stage for good. The bench runs separate timer-only and byte-only recoveries to show that each trigger works alone, then a heavy mixed phase that drives both triggers hard enough to enter the hyper stage. A long pseudo-random phase follows, with rare notifications, and its expected rate and pacing enable are recomputed every cycle from the arithmetic in the requirements.

// File: rtl/rc_pkg.sv
package rc_pkg;
  localparam int RATE_W    = 16;
  localparam int CUT_W     = 8;
  localparam logic [RATE_W-1:0] FULL_RATE = '1;

  typedef logic [RATE_W-1:0] rate_t;

  typedef enum logic [1:0] {
    STG_HALVE = 2'd0,
    STG_ADD   = 2'd1,
    STG_HYPER = 2'd2
  } stage_e;
endpackage

// File: rtl/rc_trigger.sv
module rc_trigger #(
  parameter int ACC_W  = 16,
  parameter int INC_W  = 8,
  parameter int STAGES = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic [INC_W-1:0] inc_i,
  input  logic [ACC_W-1:0] thr_i,
  output logic             fire_o,
  output logic             done_o
);
  localparam int CNT_W = $clog2(STAGES + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(STAGES);

  logic [ACC_W-1:0] acc_q;
  logic [CNT_W-1:0] cnt_q;
  logic [ACC_W:0]   sum_w;

  assign sum_w  = {1'b0, acc_q} + (ACC_W+1)'(inc_i);
  assign fire_o = (|inc_i) && (sum_w >= {1'b0, thr_i});
  assign done_o = (cnt_q >= CNT_TOP) || (fire_o && (cnt_q == CNT_TOP - 1'b1));

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else begin
      acc_q <= fire_o ? '0 : sum_w[ACC_W-1:0];
      if (fire_o && cnt_q < CNT_TOP) cnt_q <= cnt_q + 1'b1;
    end
  end

  // R8: a notification leaves the trigger empty
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (acc_q == '0 && cnt_q == '0));

  // R6/R7: the firing count saturates at the stage limit
  p_cnt_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_TOP);
endmodule

// File: rtl/rc_rate_core.sv
module rc_rate_core
  import rc_pkg::*;
#(
  parameter int STAGES = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnp_i,
  input  logic             evt_i,
  input  logic             both_done_i,
  input  logic [CUT_W-1:0] cut_i,
  input  rate_t            min_i,
  input  rate_t            ai_i,
  input  rate_t            hai_i,
  output rate_t            rate_o
);
  localparam int EV_W = $clog2(STAGES + 1);
  localparam logic [EV_W-1:0] EV_TOP = EV_W'(STAGES);

  rate_t rate_q, tgt_q, rate_d, tgt_d, cut_v, cut_c, step_v;
  logic [EV_W-1:0] evt_q, evt_d;
  logic [RATE_W+CUT_W-1:0] prod;
  logic [RATE_W:0] tsum, avg;
  stage_e stg;

  assign prod  = {{CUT_W{1'b0}}, rate_q} * {{RATE_W{1'b0}}, cut_i};
  assign cut_v = prod[RATE_W+CUT_W-1:CUT_W];
  assign cut_c = (cut_v < min_i) ? min_i : cut_v;

  always_comb begin
    if (evt_q < EV_TOP)   stg = STG_HALVE;
    else if (both_done_i) stg = STG_HYPER;
    else                  stg = STG_ADD;
  end

  assign step_v = (stg == STG_HYPER) ? hai_i : ai_i;
  assign tsum   = {1'b0, tgt_q} + {1'b0, step_v};

  always_comb begin
    rate_d = rate_q;
    tgt_d  = tgt_q;
    evt_d  = evt_q;
    avg    = '0;
    if (cnp_i) begin
      rate_d = cut_c;
      tgt_d  = rate_q;
      evt_d  = '0;
    end else if (evt_i) begin
      if (stg == STG_HALVE) evt_d = evt_q + 1'b1;
      else                  tgt_d = tsum[RATE_W] ? FULL_RATE : tsum[RATE_W-1:0];
      avg    = {1'b0, rate_q} + {1'b0, tgt_d};
      rate_d = avg[RATE_W:1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate_q <= FULL_RATE;
      tgt_q  <= FULL_RATE;
      evt_q  <= '0;
    end else begin
      rate_q <= rate_d;
      tgt_q  <= tgt_d;
      evt_q  <= evt_d;
    end
  end

  assign rate_o = rate_q;

  p_cut_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnp_i |=> rate_q <= $past(rate_q));

  p_tgt_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnp_i |=> tgt_q == $past(rate_q));

  p_halve_keeps_tgt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnp_i && evt_q < EV_TOP) |=> tgt_q == $past(tgt_q));

  p_floor_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rate_q >= min_i);

  p_under_tgt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rate_q <= tgt_q);

  p_no_evt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnp_i && !evt_i) |=> $stable(rate_q));
endmodule

// File: rtl/rc_shaper.sv
module rc_shaper #(
  parameter int RATE_W      = 16,
  parameter int BYTE_W      = 8,
  parameter int LINE_BYTES  = 8,
  parameter int BURST_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate_i,
  input  logic [BYTE_W-1:0] bytes_i,
  output logic              pace_o
);
  localparam int BAL_W = RATE_W + $clog2(BURST_BYTES + (1 << BYTE_W) + LINE_BYTES) + 2;
  localparam logic signed [BAL_W-1:0] CAP = BAL_W'(BURST_BYTES) <<< RATE_W;

  logic signed [BAL_W-1:0] bal_q, credit, debit, sum_v, bal_d;

  assign credit = BAL_W'(rate_i) * BAL_W'(LINE_BYTES);
  assign debit  = BAL_W'(bytes_i) << RATE_W;
  assign sum_v  = bal_q + credit - debit;

  always_comb begin
    if (sum_v > CAP)       bal_d = CAP;
    else if (sum_v < -CAP) bal_d = -CAP;
    else                   bal_d = sum_v;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bal_q <= '0;
    else        bal_q <= bal_d;
  end

  assign pace_o = (bal_q > 0);

  p_bal_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bal_q <= CAP) && (bal_q >= -CAP));

  p_idle_grows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bytes_i == '0 && rate_i != '0 && bal_q < CAP - credit) |=> bal_q > $past(bal_q));
endmodule

// File: rtl/cong_rate_ctl.sv
module cong_rate_ctl
  import rc_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int ACC_W       = 16,
  parameter int STAGES      = 5,
  parameter int LINE_BYTES  = 8,
  parameter int BURST_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnp_i,
  input  logic [BYTE_W-1:0] tx_bytes_i,
  input  logic              tick_i,
  input  logic [CUT_W-1:0]  cut_factor_i,
  input  logic [RATE_W-1:0] min_rate_i,
  input  logic [RATE_W-1:0] ai_step_i,
  input  logic [RATE_W-1:0] hai_step_i,
  input  logic [ACC_W-1:0]  byte_thresh_i,
  input  logic [ACC_W-1:0]  timer_period_i,
  output logic [RATE_W-1:0] rate_o,
  output logic              pace_o
);
  localparam int N_TRIG = 2;

  logic [BYTE_W-1:0] trig_inc [N_TRIG];
  logic [ACC_W-1:0]  trig_thr [N_TRIG];
  logic [N_TRIG-1:0] trig_fire, trig_done;
  rate_t             rate_w;

  assign trig_inc[0] = tx_bytes_i;
  assign trig_thr[0] = byte_thresh_i;
  assign trig_inc[1] = BYTE_W'(tick_i);
  assign trig_thr[1] = timer_period_i;

  for (genvar g = 0; g < N_TRIG; g++) begin : g_trig
    rc_trigger #(
      .ACC_W (ACC_W),
      .INC_W (BYTE_W),
      .STAGES(STAGES)
    ) u_trig (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (cnp_i),
      .inc_i (trig_inc[g]),
      .thr_i (trig_thr[g]),
      .fire_o(trig_fire[g]),
      .done_o(trig_done[g])
    );
  end

  rc_rate_core #(.STAGES(STAGES)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnp_i      (cnp_i),
    .evt_i      (|trig_fire),
    .both_done_i(&trig_done),
    .cut_i      (cut_factor_i),
    .min_i      (min_rate_i),
    .ai_i       (ai_step_i),
    .hai_i      (hai_step_i),
    .rate_o     (rate_w)
  );

  rc_shaper #(
    .RATE_W     (RATE_W),
    .BYTE_W     (BYTE_W),
    .LINE_BYTES (LINE_BYTES),
    .BURST_BYTES(BURST_BYTES)
  ) u_shaper (
    .clk    (clk),
    .rst_n  (rst_n),
    .rate_i (rate_w),
    .bytes_i(tx_bytes_i),
    .pace_o (pace_o)
  );

  assign rate_o = rate_w;

  // R7: a tick alone (no bytes) can still set off a recovery event
  p_timer_alone_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_fire[1] && tx_bytes_i == '0) |-> !trig_fire[0]);
endmodule

// File: tb/sim_cong_rate_ctl.sv
module sim_cong_rate_ctl;
  localparam int CUT  = 205;
  localparam int MINR = 16'h1000;
  localparam int RAI  = 16'h0400;
  localparam int RHAI = 16'h1000;
  localparam int BTHR = 100;
  localparam int TPER = 4;
  localparam int LB   = 8;
  localparam longint CAP = 64 * 65536;

  logic clk = 0, rst_n = 0, cnp_i = 0, tick_i = 0;
  logic [7:0] tx_bytes_i = 0;
  logic [15:0] rate_o;
  logic pace_o;

  int nchk = 0, nerr = 0;
  bit done = 0;
  longint er, et, tacc, bacc, tcnt, bcnt, evt, bal;

  always #10 clk = ~clk;

  cong_rate_ctl u0 (
    .clk(clk), .rst_n(rst_n), .cnp_i(cnp_i), .tx_bytes_i(tx_bytes_i), .tick_i(tick_i),
    .cut_factor_i(8'(CUT)), .min_rate_i(16'(MINR)), .ai_step_i(16'(RAI)),
    .hai_step_i(16'(RHAI)), .byte_thresh_i(16'(BTHR)), .timer_period_i(16'(TPER)),
    .rate_o(rate_o), .pace_o(pace_o)
  );

  task automatic model(bit c, int b, bit t);
    longint tsum, bsum, nr, st;
    bit tf, bf;
    tsum = tacc + t;
    bsum = bacc + b;
    tf = t && (tsum >= TPER);
    bf = (b != 0) && (bsum >= BTHR);
    bal = bal + er * LB - longint'(b) * 65536;
    if (bal > CAP) bal = CAP;
    if (bal < -CAP) bal = -CAP;
    if (c) begin
      nr = (er * CUT) / 256;
      if (nr < MINR) nr = MINR;
      et = er; er = nr;
      tacc = 0; bacc = 0; tcnt = 0; bcnt = 0; evt = 0;
    end else begin
      tacc = tf ? 0 : tsum;
      bacc = bf ? 0 : bsum;
      if (tf && tcnt < 5) tcnt++;
      if (bf && bcnt < 5) bcnt++;
      if (tf || bf) begin
        if (evt < 5) evt++;
        else begin
          st = (tcnt >= 5 && bcnt >= 5) ? RHAI : RAI;
          et = et + st;
          if (et > 65535) et = 65535;
        end
        er = (er + et) / 2;
      end
    end
  endtask

  task automatic check(string tag);
    nchk++;
    if (rate_o !== 16'(er)) begin
      nerr++;
      $display("FAIL %s rate: actual=%h expected=%h", tag, rate_o, 16'(er));
    end
    nchk++;
    if (pace_o !== (bal > 0)) begin
      nerr++;
      $display("FAIL R9 (%s) pace: actual=%b expected=%b", tag, pace_o, bal > 0);
    end
  endtask

  task automatic step(bit c, int b, bit t, string tag);
    cnp_i = c; tx_bytes_i = 8'(b); tick_i = t;
    @(posedge clk);
    model(c, b, t);
    @(negedge clk);
    check(tag);
    cnp_i = 0; tx_bytes_i = 0; tick_i = 0;
  endtask

  initial begin
    #(20ns * 100000);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    er = 65535; et = 65535; tacc = 0; bacc = 0; tcnt = 0; bcnt = 0; evt = 0; bal = 0;
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rst_n = 1;
    check("R1 after release");

    // R7: timer alone at full rate keeps rate at line rate; R9 pace rises
    for (int i = 0; i < 20; i++) step(0, 0, 1, "R7 idle");

    // R2 cut, then R3/R4 via timer-only recovery (slow flow)
    step(1, 0, 0, "R2 cut");
    for (int i = 0; i < 100; i++) step(0, 0, i % 2, "R4 timer-only");

    // R6: byte-only recovery, heavy sending drives pace low
    step(1, 0, 0, "R2 cut");
    for (int i = 0; i < 80; i++) step(0, 30, 0, "R6 bytes-only");

    // R6 boundary: 99 bytes no event, 1 more byte fires
    step(1, 0, 0, "R8 cut");
    step(0, 99, 0, "R6 below threshold");
    step(0, 1, 0, "R6 at threshold");

    // R5: both triggers hard, enters hyper stage
    step(1, 0, 0, "R2 cut");
    for (int i = 0; i < 120; i++) step(0, 60, 1, "R5 hyper");

    // R10: repeated cuts to the floor
    for (int i = 0; i < 25; i++) step(1, 0, 0, "R10 floor");

    // R8: notification in the same cycle as firing triggers
    for (int i = 0; i < 3; i++) step(0, 50, 1, "R8 prep");
    step(1, 100, 1, "R8 precedence");
    step(0, 99, 1, "R8 cleared acc");

    // R3: exactly five halving events after a cut, then additive
    step(1, 0, 0, "R3 cut");
    for (int i = 0; i < 7; i++) step(0, 100, 0, "R3 halving");

    // mixed pseudo-random traffic
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom;
      step((r % 211) == 0, (r[8]) ? int'(r[15:10]) : 0, (r[20:19] == 0), "R8 random");
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule